// File: doc/BRIEF.md
# Power Mode Control Register

This block holds the power-mode control register of a small 8-bit microcontroller and the logic around it. The register sits on a simple special-function-register bus: the core presents an address, a write strobe and write data, and reads return the register contents combinationally. The register holds two serial-port configuration bits, a power-off flag, a watchdog load enable, two general-purpose flags, and the power-down and idle selects.

Setting the idle or power-down select sends a one-cycle request to the clock controller. A wake input clears both selects. Power-down outranks idle, and power-down cannot be entered while the watchdog is running. The power-off flag and one serial bit are held across a warm reset, so software can tell a cold start from a warm one.

The block also samples the address-latch-enable and program-store-enable pins while reset is held. If the right pattern is present when reset is released, it latches an on-circuit emulation mode. In that mode one port floats, the other pins are weakly pulled up and the oscillator stays on. The mode is left only through a later reset.

Top module: `pwr_mode_ctl`

## Requirements
- R1: While rst_n is low and after its release, bits 7 and 4..0 of the register read 0, and idle_req_o, pd_req_o, baud_dbl_o and emu_mode_o are 0. A read at any address other than 0x87 returns 0x00. Writes are ignored while rst_n is low.
- R2: A write to address 0x87 stores the following fields, and the same fields read back at 0x87: bit 7 baud doubling (driven on baud_dbl_o), bit 6 frame-error select (driven on fe_sel_o), bit 5 power-off flag, bit 4 watchdog load enable, bits 3:2 general-purpose flags, bit 1 power-down, bit 0 idle. This holds when wdt_en_i is 0 and wdt_load_i and wake_i are low.
- R3: A write that sets bits 1 and 0 together (with wdt_en_i 0) sets only power-down. Bit 0 reads 0, only pd_req_o pulses, and power-down and idle are never both set.
- R4: A write of 1 to bit 1 while wdt_en_i is 1 leaves bit 1 at 0 and produces no pd_req_o pulse. If bit 0 of that same write is 1, idle is set instead.
- R5: In the cycle after wdt_load_i is high, bit 4 reads 0. wdt_load_i wins over a same-cycle write of 1 to that bit.
- R6: A por_i pulse sets bit 5 and clears bit 6, even while rst_n is low. A warm reset (rst_n low without por_i) leaves bits 6 and 5 unchanged.
- R7: Each 0-to-1 change of the power-down or idle select raises pd_req_o or idle_req_o for exactly one cycle: the first cycle after the write edge.
- R8: wake_i high clears the power-down and idle selects at the next edge, and takes priority over a same-cycle write.
- R9: Emulation mode (emu_mode_o) is entered only if, on every clock of the reset period, ale_i is low and psen_i is high, and ale_i is still low at the first edge with rst_n high. It then shows 1 from the following cycle. It clears only when rst_n next goes low.
- R10: While in emulation mode, p0_float_o and weak_pu_o are 1 and osc_en_o stays 1 even with power-down set. Outside emulation mode, p0_float_o and weak_pu_o are 0.
- R11: Outside emulation mode, osc_en_o is 0 exactly while the power-down select is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous warm/normal reset |
| por_i | input | 1 | Power-on detect pulse |
| sfr_addr | input | 8 | Register bus address |
| sfr_we | input | 1 | Register bus write strobe |
| sfr_wdata | input | 8 | Register bus write data |
| sfr_rdata | output | 8 | Register bus read data |
| wdt_en_i | input | 1 | Watchdog running |
| wdt_load_i | input | 1 | Watchdog reload strobe |
| wake_i | input | 1 | Wake / interrupt exit from idle or power-down |
| ale_i | input | 1 | Address-latch-enable pin level |
| psen_i | input | 1 | Program-store-enable pin level |
| idle_req_o | output | 1 | One-cycle idle request to clock controller |
| pd_req_o | output | 1 | One-cycle power-down request to clock controller |
| baud_dbl_o | output | 1 | Serial baud doubling |
| fe_sel_o | output | 1 | Serial control bit 7 frame-error select |
| emu_mode_o | output | 1 | Emulation mode active |
| p0_float_o | output | 1 | Force port 0 drivers off |
| weak_pu_o | output | 1 | Weak pull-up on other ports and strobes |
| osc_en_o | output | 1 | Oscillator enable |

## Verification
The select bits are driven with idle alone, power-down alone, both together, and power-down while the watchdog runs. Together these separate correct precedence and refusal from a design that simply stores the written bits. Load-enable writes are raced against a same-cycle reload strobe to show that the self-clear has priority. Warm and cold resets are alternated to show which bits survive which reset. Reset sequences are run with the full emulation pattern and with each of its three conditions broken in turn (pin high during reset, program strobe low, pin high at release), so that every term of the entry condition is exercised.

// File: rtl/pwr_mode_ctl.sv
module pwr_mode_ctl #(
  parameter int AW = 8,
  parameter logic [AW-1:0] REG_ADDR = AW'('h87)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          por_i,
  input  logic [AW-1:0] sfr_addr,
  input  logic          sfr_we,
  input  logic [7:0]    sfr_wdata,
  output logic [7:0]    sfr_rdata,
  input  logic          wdt_en_i,
  input  logic          wdt_load_i,
  input  logic          wake_i,
  input  logic          ale_i,
  input  logic          psen_i,
  output logic          idle_req_o,
  output logic          pd_req_o,
  output logic          baud_dbl_o,
  output logic          fe_sel_o,
  output logic          emu_mode_o,
  output logic          p0_float_o,
  output logic          weak_pu_o,
  output logic          osc_en_o
);
  logic smod1, smod0, pof, wle, gf1, gf0, pd, idl;
  logic pd_q, idl_q;
  logic in_rst_q, emu_arm, emu;

  wire hit    = (sfr_addr == REG_ADDR);
  wire wr_hit = sfr_we && hit && rst_n;
  wire pd_ok  = sfr_wdata[1] && !wdt_en_i;

  always_ff @(posedge clk) begin
    if (por_i) begin
      pof   <= 1'b1;
      smod0 <= 1'b0;
    end else if (wr_hit) begin
      pof   <= sfr_wdata[5];
      smod0 <= sfr_wdata[6];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {smod1, wle, gf1, gf0, pd, idl} <= '0;
      {pd_q, idl_q} <= '0;
    end else begin
      pd_q  <= pd;
      idl_q <= idl;
      if (wr_hit) {smod1, gf1, gf0} <= {sfr_wdata[7], sfr_wdata[3:2]};
      if (wdt_load_i) wle <= 1'b0;
      else if (wr_hit) wle <= sfr_wdata[4];
      if (wake_i) begin
        pd  <= 1'b0;
        idl <= 1'b0;
      end else if (wr_hit) begin
        pd  <= pd_ok;
        idl <= sfr_wdata[0] && !pd_ok;
      end
    end
  end

  always_ff @(posedge clk) begin
    in_rst_q <= !rst_n;
    if (!rst_n) begin
      emu     <= 1'b0;
      emu_arm <= (in_rst_q ? emu_arm : 1'b1) && !ale_i && psen_i;
    end else if (in_rst_q) begin
      emu <= emu_arm && !ale_i;
    end
  end

  assign sfr_rdata  = hit ? {smod1, smod0, pof, wle, gf1, gf0, pd, idl} : 8'h00;
  assign pd_req_o   = pd && !pd_q;
  assign idle_req_o = idl && !idl_q;
  assign baud_dbl_o = smod1;
  assign fe_sel_o   = smod0;
  assign emu_mode_o = emu;
  assign p0_float_o = emu;
  assign weak_pu_o  = emu;
  assign osc_en_o   = emu || !pd;

  // R3
  pd_idl_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(pd && idl));
  // R4
  pd_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(pd) |-> $past(!wdt_en_i));
  // R5
  wle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n) wdt_load_i |=> !wle);
  // R7
  pd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) pd_req_o |=> !pd_req_o);
  // R7
  idl_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) idle_req_o |=> !idle_req_o);
  // R8
  wake_clear_chk: assert property (@(posedge clk) disable iff (!rst_n) wake_i |=> (!pd && !idl));
  // R9
  emu_entry_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(emu_mode_o) |-> $past(in_rst_q));
endmodule

// File: tb/pwr_mode_ctl_tb.sv
module pwr_mode_ctl_tb;
  logic clk = 0, rst_n = 0, por_i = 0;
  logic [7:0] sfr_addr = 8'h87, sfr_wdata = 0, sfr_rdata;
  logic sfr_we = 0, wdt_en_i = 0, wdt_load_i = 0, wake_i = 0, ale_i = 1, psen_i = 1;
  logic idle_req_o, pd_req_o, baud_dbl_o, fe_sel_o, emu_mode_o, p0_float_o, weak_pu_o, osc_en_o;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  pwr_mode_ctl u_dut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] d);
    sfr_addr = 8'h87; sfr_wdata = d; sfr_we = 1;
    @(posedge clk); @(negedge clk);
    sfr_we = 0;
  endtask

  task automatic do_reset(logic por);
    rst_n = 0; por_i = por;
    repeat (3) @(negedge clk);
    por_i = 0; rst_n = 1;
    @(negedge clk);
  endtask

  task automatic t_reset;
    rst_n = 0; por_i = 1;
    @(negedge clk);
    wr(8'hFF);
    por_i = 0;
    @(negedge clk);
    chk("R1 rd", sfr_rdata, 8'h20);
    rst_n = 1;
    @(negedge clk);
    chk("R1 rd", sfr_rdata, 8'h20);
    chk("R1 req", {idle_req_o, pd_req_o, baud_dbl_o, emu_mode_o}, 0);
    sfr_addr = 8'h80;
    #0 chk("R1 other addr", sfr_rdata, 8'h00);
    sfr_addr = 8'h87;
  endtask

  task automatic t_fields;
    wr(8'hDC);
    chk("R2 rd", sfr_rdata, 8'hDC);
    chk("R2 outs", {baud_dbl_o, fe_sel_o}, 2'b11);
    wr(8'h28);
    chk("R2 rd", sfr_rdata, 8'h28);
    chk("R2 outs", {baud_dbl_o, fe_sel_o}, 2'b00);
  endtask

  task automatic t_idle_pd;
    wr(8'h01);
    chk("R7 idle pulse", {idle_req_o, pd_req_o}, 2'b10);
    @(negedge clk);
    chk("R7 idle single", idle_req_o, 0);
    chk("R2 idle bit", sfr_rdata, 8'h01);
    wake_i = 1; sfr_wdata = 8'h01; sfr_we = 1;
    @(negedge clk);
    wake_i = 0; sfr_we = 0;
    chk("R8 wake", sfr_rdata[1:0], 0);
    wr(8'h02);
    chk("R7 pd pulse", {idle_req_o, pd_req_o}, 2'b01);
    chk("R11 osc off", osc_en_o, 0);
    chk("R10 no float", {p0_float_o, weak_pu_o}, 0);
    @(negedge clk);
    chk("R7 pd single", pd_req_o, 0);
    wake_i = 1; @(negedge clk); wake_i = 0;
    chk("R8 wake pd", sfr_rdata[1:0], 0);
    chk("R11 osc on", osc_en_o, 1);
  endtask

  task automatic t_prec;
    wr(8'h03);
    chk("R3 rd", sfr_rdata[1:0], 2'b10);
    chk("R3 req", {idle_req_o, pd_req_o}, 2'b01);
    wake_i = 1; @(negedge clk); wake_i = 0;
  endtask

  task automatic t_refuse;
    wdt_en_i = 1;
    wr(8'h02);
    chk("R4 pd refused", sfr_rdata[1:0], 0);
    chk("R4 no pulse", pd_req_o, 0);
    chk("R4 osc", osc_en_o, 1);
    wr(8'h03);
    chk("R4 idle instead", sfr_rdata[1:0], 2'b01);
    chk("R4 idle pulse", {idle_req_o, pd_req_o}, 2'b10);
    wdt_en_i = 0;
    wake_i = 1; @(negedge clk); wake_i = 0;
  endtask

  task automatic t_wle;
    wr(8'h10);
    chk("R5 set", sfr_rdata[4], 1);
    wdt_load_i = 1; @(negedge clk); wdt_load_i = 0;
    chk("R5 clear", sfr_rdata[4], 0);
    wdt_load_i = 1;
    wr(8'h10);
    wdt_load_i = 0;
    chk("R5 load wins", sfr_rdata[4], 0);
  endtask

  task automatic t_pof;
    wr(8'hC0);
    do_reset(0);
    chk("R6 warm keep", sfr_rdata, 8'h40);
    wr(8'h20);
    do_reset(0);
    chk("R6 warm keep pof", sfr_rdata, 8'h20);
    wr(8'h40);
    do_reset(1);
    chk("R6 por", sfr_rdata, 8'h20);
  endtask

  task automatic emu_seq(logic ale_rst, logic psen_rst, logic ale_rel, logic exp, string tag);
    rst_n = 0; ale_i = ale_rst; psen_i = psen_rst;
    repeat (3) @(negedge clk);
    ale_i = ale_rel; rst_n = 1;
    @(negedge clk);
    chk(tag, emu_mode_o, exp);
    ale_i = 1; psen_i = 1;
    @(negedge clk);
    chk(tag, emu_mode_o, exp);
  endtask

  task automatic t_emu;
    emu_seq(0, 1, 0, 1, "R9 entry");
    chk("R10 pins", {p0_float_o, weak_pu_o}, 2'b11);
    wr(8'h02);
    chk("R10 osc held", osc_en_o, 1);
    chk("R10 pd set", sfr_rdata[1], 1);
    wake_i = 1; @(negedge clk); wake_i = 0;
    emu_seq(1, 1, 0, 0, "R9 ale high in reset");
    emu_seq(0, 0, 0, 0, "R9 psen low");
    emu_seq(0, 1, 1, 0, "R9 ale high at release");
    chk("R10 no emu pins", {p0_float_o, weak_pu_o}, 0);
  endtask

  initial begin
    fork
      begin
        t_reset(); t_fields(); t_idle_pd(); t_prec(); t_refuse(); t_wle(); t_pof(); t_emu();
      end
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule